// File: doc/BRIEF.md
# Serial DAC Control Register Slave

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host writes 24-bit frames over a three-wire serial link made of an active-low frame select, a serial clock and a data line. The block keeps the DAC code register and a 2-bit power-down selection register. It presents their contents to the analog section together with a one-cycle update strobe that marks every commit.

The serial pins are not used as clocks. All three pass through multi-flop synchronizers into the system clock domain. Falling edges of the serial clock are found there by comparing successive samples. The system clock must run at least four times as fast as the serial clock. A frame is accepted only once its twenty-fourth data bit has arrived. If frame select rises earlier, the partial frame is dropped with no trace. A frame holding ones in every bit position is a software reset that returns the converter to midscale with the output active.

Top module: `dac_serial_front`

## Requirements
- R1: While reset is held and after it is released, the code output is 0x8000 (midscale), the mode output is 00 and the update strobe is low, until the first complete frame commits.
- R2: While frame select is low, each falling serial clock edge shifts one data bit in, most significant bit first. In the 24-bit word, bits 17..16 carry the mode and bits 15..0 carry the code.
- R3: On the 24th falling edge of a frame, the code and mode are written together and the update strobe is high for exactly one cycle. The outputs change on the third rising system clock edge after the serial clock pin falls. Code and mode never change in any cycle without the strobe.
- R4: If frame select rises before the 24th falling edge, neither code nor mode changes and no strobe is produced. The next frame is received from an empty register, with no bits left over from the aborted frame.
- R5: After the 24th edge, further serial clock edges with frame select still low are ignored until frame select goes high and falls again. The bit counter never exceeds 24.
- R6: The mode encoding is 00 normal output, 01 output floating, 10 weak pull to ground and 11 strong pull to ground. Any mode value loads the frame's code field unchanged, so entering power-down does not clear or alter the stored code.
- R7: A frame of all ones (0xFFFFFF) sets the code to 0x8000 and the mode to 00 and raises the strobe. Raising frame select after such a frame does not undo it.
- R8: Bits 23..18 of a frame that is not all ones have no effect on the stored code or mode.
- R9: Serial clock edges while frame select is high shift nothing and change no output.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fsel_n | input | 1 | Serial frame select, active low |
| sclk_pin | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_pin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 16 | Current DAC code |
| pd_mode | output | 2 | Current power-down selection (00 normal, 01 floating, 10 weak pull, 11 strong pull) |
| upd_pulse | output | 1 | One-cycle strobe on each committed frame |

## Verification
A miscounted bit position or a counter that is not cleared by frame select shows at the ports on the next committed frame. In that case the code comes out shifted, or the strobe lands on the wrong serial edge, and a clock-by-clock comparison catches it within three system cycles of the intended commit. A counter that fails to saturate shows as a second strobe when extra serial clocks follow a complete frame. A missing abort clear shows as garbled data on the frame after an interrupted one. A broken software reset check shows as code 0xFFFF and mode 11 in place of midscale and normal.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   // Power-down selection carried in the frame; the value picks the output load
   typedef enum logic [1:0] {
      PD_ACTIVE      = 2'b00,
      PD_FLOAT       = 2'b01,
      PD_PULL_WEAK   = 2'b10,
      PD_PULL_STRONG = 2'b11
   } pd_sel_e;

   localparam int PD_W = $bits(pd_sel_e);

endpackage

// File: rtl/dacfe_pin_sync.sv
module dacfe_pin_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dacfe_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= RST_VAL;
      end else begin
         chain[0] <= async_i;
      end
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= RST_VAL;
            end else begin
               chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsel_s,
   input  logic               sclk_s,
   input  logic               sdata_s,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_word
);

   localparam int CNT_W = $clog2(FRAME_W + 1);

   generate
      if (FRAME_W < 3) begin : g_bad_frame
         $error("dacfe_frame_rx: FRAME_W must be at least 3");
      end
   endgenerate

   logic               sclk_d;
   logic               sclk_fall;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-2:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
      end
   end

   assign sclk_fall = sclk_d & ~sclk_s;

   // Bit counter saturates at FRAME_W; frame select high empties everything
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (fsel_s) begin
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (sclk_fall && (bit_cnt != CNT_W'(FRAME_W))) begin
         bit_cnt <= bit_cnt + CNT_W'(1);
         shreg   <= {shreg[FRAME_W-3:0], sdata_s};
      end
   end

   assign frame_done = ~fsel_s & sclk_fall & (bit_cnt == CNT_W'(FRAME_W - 1));
   assign frame_word = {shreg, sdata_s};

   assert_cnt_sat_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W));

   assert_fall_gap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      sclk_fall |=> !sclk_fall);

endmodule

// File: rtl/dacfe_reg_bank.sv
module dacfe_reg_bank
   import dacfe_pkg::*;
#(
   parameter int CODE_W   = 16,
   parameter int PAD_W    = 6,
   parameter bit SWRST_EN = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            frame_done,
   input  logic [PAD_W+PD_W+CODE_W-1:0]    frame_word,
   output logic [CODE_W-1:0]               code_o,
   output logic [PD_W-1:0]                 mode_o,
   output logic                            upd_o
);

   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   logic    is_swrst;
   pd_sel_e mode_q;

   generate
      if (SWRST_EN) begin : g_swrst
         assign is_swrst = &frame_word;
      end else begin : g_no_swrst
         assign is_swrst = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= MID_CODE;
         mode_q <= PD_ACTIVE;
         upd_o  <= 1'b0;
      end else begin
         upd_o <= frame_done;
         if (frame_done) begin
            if (is_swrst) begin
               code_o <= MID_CODE;
               mode_q <= PD_ACTIVE;
            end else begin
               code_o <= frame_word[CODE_W-1:0];
               mode_q <= pd_sel_e'(frame_word[CODE_W +: PD_W]);
            end
         end
      end
   end

   assign mode_o = mode_q;

   generate
      if (SWRST_EN) begin : g_swrst_chk
         assert_swrst_mid_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (frame_done && (&frame_word)) |=> (code_o == MID_CODE && mode_o == PD_W'(0)));
      end
   endgenerate

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
   import dacfe_pkg::*;
#(
   parameter int CODE_W      = 16,
   parameter int PAD_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit SWRST_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsel_n,
   input  logic              sclk_pin,
   input  logic              sdata_pin,
   output logic [CODE_W-1:0] dac_code,
   output logic [PD_W-1:0]   pd_mode,
   output logic              upd_pulse
);

   localparam int FRAME_W = PAD_W + PD_W + CODE_W;

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("dac_serial_front: CODE_W must be at least 2");
      end
   endgenerate

   logic [2:0]         pins_s;
   logic               fsel_s, sclk_s, sdata_s;
   logic               frame_done;
   logic [FRAME_W-1:0] frame_word;

   dacfe_pin_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({fsel_n, sclk_pin, sdata_pin}),
      .sync_o  (pins_s)
   );

   assign {fsel_s, sclk_s, sdata_s} = pins_s;

   dacfe_frame_rx #(
      .FRAME_W (FRAME_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsel_s     (fsel_s),
      .sclk_s     (sclk_s),
      .sdata_s    (sdata_s),
      .frame_done (frame_done),
      .frame_word (frame_word)
   );

   dacfe_reg_bank #(
      .CODE_W   (CODE_W),
      .PAD_W    (PAD_W),
      .SWRST_EN (SWRST_EN)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .frame_word (frame_word),
      .code_o     (dac_code),
      .mode_o     (pd_mode),
      .upd_o      (upd_pulse)
   );

   assert_strobe_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |=> !upd_pulse);

   assert_hold_without_strobe_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dac_code) || !$stable(pd_mode)) |-> upd_pulse);

   assert_no_commit_idle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      fsel_s |=> !upd_pulse);

endmodule

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsel_n = 1'b1;
   logic        sclk_pin = 1'b1;
   logic        sdata_pin = 1'b0;
   logic [15:0] dac_code;
   logic [1:0]  pd_mode;
   logic        upd_pulse;

   int checks = 0;
   int failed = 0;
   int cyc = 0;
   int strobes = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dac_serial_front dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsel_n    (fsel_n),
      .sclk_pin  (sclk_pin),
      .sdata_pin (sdata_pin),
      .dac_code  (dac_code),
      .pd_mode   (pd_mode),
      .upd_pulse (upd_pulse)
   );

   // Behavioural reference: pins seen two cycles late, then frame rules
   bit          q_fs[$], q_sc[$], q_sd[$];
   bit          m_prev_sc = 1'b0;
   int          m_bits = 0;
   logic [23:0] m_word = '0;
   logic [15:0] m_code = 16'h8000;
   logic [1:0]  m_mode = 2'b00;
   bit          m_upd = 1'b0;

   always @(posedge clk) begin
      bit fs, sc, sd;
      cyc++;
      if (!rst_n) begin
         q_fs = {1'b1, 1'b1}; q_sc = {1'b0, 1'b0}; q_sd = {1'b0, 1'b0};
         m_prev_sc = 1'b0; m_bits = 0; m_word = '0;
         m_code = 16'h8000; m_mode = 2'b00; m_upd = 1'b0;
      end else begin
         fs = q_fs[0]; sc = q_sc[0]; sd = q_sd[0];
         m_upd = 1'b0;
         if (fs) begin
            m_bits = 0; m_word = '0;
         end else if (m_prev_sc && !sc && m_bits < 24) begin
            m_word = {m_word[22:0], sd};
            m_bits++;
            if (m_bits == 24) begin
               m_upd = 1'b1;
               if (m_word == 24'hFFFFFF) begin
                  m_code = 16'h8000; m_mode = 2'b00;
               end else begin
                  m_code = m_word[15:0]; m_mode = m_word[17:16];
               end
            end
         end
         m_prev_sc = sc;
         void'(q_fs.pop_front()); void'(q_sc.pop_front()); void'(q_sd.pop_front());
         q_fs.push_back(fsel_n); q_sc.push_back(sclk_pin); q_sd.push_back(sdata_pin);
      end
      if (cyc > 100000 && !finished) begin
         failed++;
         $display("FAIL watchdog: run hung, got cycle %0d expected under 100000", cyc);
         $display("  [TB] %0d tests run, %0d failed", checks, failed);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (cyc > 0) begin
         checks++;
         if (dac_code !== m_code || pd_mode !== m_mode || upd_pulse !== m_upd) begin
            failed++;
            $display("FAIL R3 cycle %0d: got code=%h mode=%b upd=%b expected code=%h mode=%b upd=%b",
                     cyc, dac_code, pd_mode, upd_pulse, m_code, m_mode, m_upd);
         end
         if (upd_pulse === 1'b1) strobes++;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_bits(input logic [23:0] w, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         sdata_pin = w[23-i];
         sclk_pin = 1'b1;
         idle(4);
         sclk_pin = 1'b0;
         idle(4);
      end
      sclk_pin = 1'b1;
      idle(4);
   endtask

   task automatic send(input logic [23:0] w, input int nbits, input bit hold_low);
      fsel_n = 1'b0;
      idle(4);
      pulse_bits(w, nbits);
      if (!hold_low) fsel_n = 1'b1;
      idle(8);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failed++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   initial begin
      int s0;
      idle(3);
      chk("R1 code in reset", 32'(dac_code), 32'h8000);
      chk("R1 mode in reset", 32'(pd_mode), 32'h0);
      rst_n = 1'b1;
      idle(6);
      chk("R1 code after reset", 32'(dac_code), 32'h8000);
      chk("R1 strobe after reset", 32'(upd_pulse), 32'h0);

      // R2/R3: plain write, mode normal
      s0 = strobes;
      send(24'h00_1234, 24, 1'b0);
      chk("R2 code 0x1234", 32'(dac_code), 32'h1234);
      chk("R3 one strobe per frame", 32'(strobes - s0), 32'd1);

      // R6: floating mode with code
      send(24'h01_BEEF, 24, 1'b0);
      chk("R6 code with mode 01", 32'(dac_code), 32'hBEEF);
      chk("R6 mode 01", 32'(pd_mode), 32'h1);

      // R6: strong pull mode keeps the frame code as given
      send(24'h03_0001, 24, 1'b0);
      chk("R6 code with mode 11", 32'(dac_code), 32'h0001);
      chk("R6 mode 11", 32'(pd_mode), 32'h3);

      // R4: abort after 10 bits
      s0 = strobes;
      send(24'hFF_FFFF, 10, 1'b0);
      chk("R4 code after abort", 32'(dac_code), 32'h0001);
      chk("R4 mode after abort", 32'(pd_mode), 32'h3);
      chk("R4 no strobe on abort", 32'(strobes - s0), 32'd0);
      send(24'h00_5A5A, 24, 1'b0);
      chk("R4 clean frame after abort", 32'(dac_code), 32'h5A5A);
      chk("R4 mode after clean frame", 32'(pd_mode), 32'h0);

      // R5: extra edges while frame select stays low
      s0 = strobes;
      send(24'h02_C3C3, 24, 1'b1);
      pulse_bits(24'hFFFFFF, 8);
      fsel_n = 1'b1;
      idle(8);
      chk("R5 code kept after extra edges", 32'(dac_code), 32'hC3C3);
      chk("R5 mode kept after extra edges", 32'(pd_mode), 32'h2);
      chk("R5 single strobe", 32'(strobes - s0), 32'd1);

      // R9: clocks with frame select high
      s0 = strobes;
      pulse_bits(24'h00_0000, 24);
      idle(8);
      chk("R9 code unchanged", 32'(dac_code), 32'hC3C3);
      chk("R9 no strobe", 32'(strobes - s0), 32'd0);

      // R8: nonzero pad bits
      send({6'h2A, 2'b10, 16'h4321}, 24, 1'b0);
      chk("R8 code with pad bits", 32'(dac_code), 32'h4321);
      chk("R8 mode with pad bits", 32'(pd_mode), 32'h2);

      // R7 boundary: one bit short of all ones is an ordinary write
      send(24'hFF_FFFE, 24, 1'b0);
      chk("R7 near-reset code", 32'(dac_code), 32'hFFFE);
      chk("R7 near-reset mode", 32'(pd_mode), 32'h3);

      // R7: software reset, frame select held low then raised
      s0 = strobes;
      send(24'hFF_FFFF, 24, 1'b1);
      chk("R7 soft reset code", 32'(dac_code), 32'h8000);
      chk("R7 soft reset mode", 32'(pd_mode), 32'h0);
      fsel_n = 1'b1;
      idle(8);
      chk("R7 reset survives sync rise", 32'(dac_code), 32'h8000);
      chk("R7 reset strobe", 32'(strobes - s0), 32'd1);

      // R1: hardware reset after activity
      send(24'h00_0F0F, 24, 1'b0);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(4);
      chk("R1 code after second reset", 32'(dac_code), 32'h8000);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, failed);
      $finish;
   end

endmodule